// File: doc/BRIEF.md
# Processor-Side Transfer Acknowledge Controller

This block closes each processor access that passes through a bus-sizing bridge. It watches the processor's chip select. It learns from the peripheral sequencer when the last narrow transfer has finished. It then raises the transfer acknowledge at the right half-clock state and lets it fall again in one of two ways. For a read, it also enables the bridge's 32-bit processor data drivers with the read data the bridge has already latched.

Timing is counted in half-clock states. Even states are the bus-clock-high half and odd states the clock-low half. The block runs from a clock at twice the bus rate, so every half state is one cycle of `clk2x`. A phase bit marks which half is current, so that all logic uses a single clock edge.

The acknowledge is always held for the two states that follow its assertion. On the next bus-clock rising edge there are two cases:
- If chip select is already released at that edge, the acknowledge falls on that edge.
- If chip select is still held at that edge, the acknowledge falls combinationally as soon as chip select is released.

If chip select is released before the acknowledge appears, the access is abandoned and a one-cycle abort pulse is raised.

Top module: `tac_top`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `acc_ack`, `dbus_oe`, `abort_pulse` and `bclk_hi` are all 0, and `dbus_out` is zero.
- R2: An access starts only on a bus-clock rising edge (a `clk2x` edge at which `bclk_hi` is 0 before the edge). At that edge `cs_n` must be 0, and at the previous rising edge `cs_n` must have been 1. If `cs_n` was not seen high on a rising edge since the last access, a low `cs_n` starts nothing and `xfer_done` is ignored.
- R3: In a started access, `xfer_done` is high for one cycle in an odd state (`bclk_hi` = 0). If `cs_n` stays 0, `acc_ack` goes to 1 on the next edge, which is the entry to the even state that follows.
- R4: Once `acc_ack` rises, it stays 1 for that even state and the odd state after it, whatever `cs_n` does.
- R5: If `cs_n` is 1 at the first rising edge after the acknowledge state pair, `acc_ack` goes to 0 on that edge.
- R6: If `cs_n` is still 0 at that edge, `acc_ack` stays 1. It then goes to 0 in the same cycle in which `cs_n` becomes 1, without waiting for an edge.
- R7: If `cs_n` is 1 at any edge while a started access waits for `xfer_done`, the access ends without `acc_ack`. `abort_pulse` is 1 for exactly the following cycle.
- R8: In a read access (`is_read` = 1 at the start edge), `dbus_oe` equals `acc_ack` and `dbus_out` equals `rd_data` while it is 1. In a write access, `dbus_oe` stays 0.
- R9: When no access is in progress, `acc_ack` and `dbus_oe` are 0. Whenever `dbus_oe` is 0, `dbus_out` is zero.
- R10: `bclk_hi` inverts on every `clk2x` edge after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Clock at twice the bus clock rate; one cycle per half state |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Processor chip select, active low |
| is_read | input | 1 | Access direction, captured at the start edge (1 = read) |
| xfer_done | input | 1 | One-cycle pulse from the peripheral sequencer: final transfer finished |
| rd_data | input | DATA_W | Read data already latched by the bridge |
| acc_ack | output | 1 | Transfer acknowledge to the processor, active high |
| dbus_oe | output | 1 | Output enable for the processor data drivers |
| dbus_out | output | DATA_W | Data for the processor data drivers, zero when not enabled |
| abort_pulse | output | 1 | One-cycle flag after an early chip-select release |
| bclk_hi | output | 1 | 1 in even (bus-clock-high) states |

## Verification
The properties assume the following about the inputs:
- `cs_n` changes at most once between `clk2x` edges.
- `xfer_done` comes only while an access waits for it, and only in an odd state, as the peripheral sequencer guarantees.
- Chip select is never reasserted so quickly that a release goes unseen at a rising edge before a new access is meant to start.

The stimulus follows these rules. It changes inputs just after an edge and waits for an odd state before placing the completion pulse. There is one exception: to exercise the idle rule, the bench deliberately reasserts chip select before a rising edge can observe the release.

// File: rtl/tac_pkg.sv
// Package: shared types for the transfer acknowledge controller.
// Assumes: one clk2x cycle corresponds to one half-clock bus state.
package tac_pkg;

    // Access progress as seen from the processor side.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // no access; waiting for a qualified chip select
        ST_WAIT = 2'd1,   // access started; waiting for peripheral completion
        ST_HOLD = 2'd2,   // acknowledge held for the mandatory two states
        ST_LATE = 2'd3    // acknowledge follows chip select combinationally
    } tac_state_t;

endpackage

// File: rtl/tac_phase.sv
// Module: tac_phase
// Tracks which half of the bus clock is current from a double-rate clock.
// Assumes: reset lands the block in an odd (clock-low) state, so the first
// edge after reset is a bus-clock rising edge.
module tac_phase (
    input  logic clk2x,
    input  logic rst_n,
    output logic bclk_hi,
    output logic rise_next
);

    logic phase_q;

    // Flip the half-state marker on every double-rate edge.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            phase_q <= 1'b0;
        end else begin
            phase_q <= ~phase_q;
        end
    end

    assign bclk_hi   = phase_q;
    assign rise_next = ~phase_q;

endmodule

// File: rtl/tac_fsm.sv
// Module: tac_fsm
// Sequences one processor access: qualified start, wait for completion,
// two-state acknowledge hold, then synchronous or late release.
// Assumes: xfer_done pulses only while waiting, in an odd state.
module tac_fsm
    import tac_pkg::*;
(
    input  logic       clk2x,
    input  logic       rst_n,
    input  logic       rise_next,
    input  logic       cs_act,
    input  logic       is_read,
    input  logic       xfer_done,
    output tac_state_t state,
    output logic       read_q,
    output logic       abort_pulse
);

    tac_state_t state_q;
    logic       armed_q;
    logic       done_q;
    logic       abort_q;

    // Record at each rising edge whether chip select was released there.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
        end else if (rise_next) begin
            armed_q <= ~cs_act;
        end
    end

    // Main access sequencer with early-release detection.
    always_ff @(posedge clk2x) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b0;
            abort_q <= 1'b0;
            read_q  <= 1'b0;
        end else begin
            abort_q <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    done_q <= 1'b0;
                    if (rise_next && armed_q && cs_act) begin
                        state_q <= ST_WAIT;
                        read_q  <= is_read;
                    end
                end
                ST_WAIT: begin
                    if (!cs_act) begin
                        state_q <= ST_IDLE;
                        abort_q <= 1'b1;
                    end else if (rise_next && (done_q || xfer_done)) begin
                        state_q <= ST_HOLD;
                        done_q  <= 1'b0;
                    end else if (xfer_done) begin
                        done_q <= 1'b1;
                    end
                end
                ST_HOLD: begin
                    if (rise_next) begin
                        state_q <= cs_act ? ST_LATE : ST_IDLE;
                    end
                end
                ST_LATE: begin
                    if (!cs_act) begin
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign state       = state_q;
    assign abort_pulse = abort_q;

endmodule

// File: rtl/tac_drive.sv
// Module: tac_drive
// Forms the acknowledge and the data-driver controls from the sequencer
// state and the live chip select.
// Assumes: the pad ring turns dbus_oe/dbus_out into a tri-state bus.
module tac_drive
    import tac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  tac_state_t        state,
    input  logic              cs_act,
    input  logic              read_q,
    input  logic [DATA_W-1:0] rd_data,
    output logic              acc_ack,
    output logic              dbus_oe,
    output logic [DATA_W-1:0] dbus_out
);

    // Acknowledge: held unconditionally, then tied to chip select.
    always_comb begin
        acc_ack = (state == ST_HOLD) || ((state == ST_LATE) && cs_act);
    end

    // Data drivers follow the acknowledge on reads only.
    always_comb begin
        dbus_oe  = acc_ack && read_q;
        dbus_out = dbus_oe ? rd_data : '0;
    end

endmodule

// File: rtl/tac_top.sv
// Module: tac_top
// Processor-side transfer acknowledge controller of a bus-sizing bridge.
// Assumes: clk2x runs at twice the bus clock; inputs are synchronous to it.
module tac_top
    import tac_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk2x,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              is_read,
    input  logic              xfer_done,
    input  logic [DATA_W-1:0] rd_data,
    output logic              acc_ack,
    output logic              dbus_oe,
    output logic [DATA_W-1:0] dbus_out,
    output logic              abort_pulse,
    output logic              bclk_hi
);

    logic       cs_act;
    logic       rise_next;
    logic       read_q;
    tac_state_t state;

    assign cs_act = ~cs_n;

    tac_phase u_phase (
        .clk2x     (clk2x),
        .rst_n     (rst_n),
        .bclk_hi   (bclk_hi),
        .rise_next (rise_next)
    );

    tac_fsm u_fsm (
        .clk2x       (clk2x),
        .rst_n       (rst_n),
        .rise_next   (rise_next),
        .cs_act      (cs_act),
        .is_read     (is_read),
        .xfer_done   (xfer_done),
        .state       (state),
        .read_q      (read_q),
        .abort_pulse (abort_pulse)
    );

    tac_drive #(.DATA_W(DATA_W)) u_drive (
        .state    (state),
        .cs_act   (cs_act),
        .read_q   (read_q),
        .rd_data  (rd_data),
        .acc_ack  (acc_ack),
        .dbus_oe  (dbus_oe),
        .dbus_out (dbus_out)
    );

endmodule

// File: rtl/tac_checker.sv
// Module: tac_checker
// Temporal properties of the acknowledge controller, bound to tac_top.
// Assumes: inputs follow the protocol described in the brief.
module tac_checker (
    input logic clk2x,
    input logic rst_n,
    input logic cs_n,
    input logic acc_ack,
    input logic dbus_oe,
    input logic abort_pulse,
    input logic bclk_hi
);

    // R4: a fresh acknowledge survives into the next state.
    p_ack_hold_r4: assert property (@(posedge clk2x) disable iff (!rst_n)
        $rose(acc_ack) |=> acc_ack);

    // R3: the acknowledge first appears in an even state.
    p_ack_even_r3: assert property (@(posedge clk2x) disable iff (!rst_n)
        $rose(acc_ack) |-> bclk_hi);

    // R8: data drivers never outlive the acknowledge.
    p_oe_in_ack_r8: assert property (@(posedge clk2x) disable iff (!rst_n)
        dbus_oe |-> acc_ack);

    // R7: abort is a single-cycle pulse.
    p_abort_once_r7: assert property (@(posedge clk2x) disable iff (!rst_n)
        abort_pulse |=> !abort_pulse);

    // R7: an aborted access carries no acknowledge.
    p_abort_no_ack_r7: assert property (@(posedge clk2x) disable iff (!rst_n)
        abort_pulse |-> !acc_ack);

    // R6: an acknowledge seen with chip select released must be in its hold pair.
    p_late_follows_cs_r6: assert property (@(posedge clk2x) disable iff (!rst_n)
        (acc_ack && cs_n && bclk_hi) |-> $rose(acc_ack));

    // R10: the phase marker alternates on every edge.
    p_phase_flip_r10: assert property (@(posedge clk2x) disable iff (!rst_n)
        1'b1 |=> (bclk_hi != $past(bclk_hi)));

endmodule

bind tac_top tac_checker u_chk (
    .clk2x       (clk2x),
    .rst_n       (rst_n),
    .cs_n        (cs_n),
    .acc_ack     (acc_ack),
    .dbus_oe     (dbus_oe),
    .abort_pulse (abort_pulse),
    .bclk_hi     (bclk_hi)
);

// File: tb/tac_top_tb.sv
module tac_top_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;

    logic          clk2x = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          is_read = 1'b0;
    logic          xfer_done = 1'b0;
    logic [DW-1:0] rd_data = 32'hCAFE_0123;
    logic          acc_ack, dbus_oe, abort_pulse, bclk_hi;
    logic [DW-1:0] dbus_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done_run = 1'b0;

    always #(CLK_PERIOD/2) clk2x = ~clk2x;

    tac_top #(.DATA_W(DW)) u_dut (
        .clk2x(clk2x), .rst_n(rst_n), .cs_n(cs_n), .is_read(is_read),
        .xfer_done(xfer_done), .rd_data(rd_data), .acc_ack(acc_ack),
        .dbus_oe(dbus_oe), .dbus_out(dbus_out), .abort_pulse(abort_pulse),
        .bclk_hi(bclk_hi)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Behavioural reference: half-state position within the access.
    // pos: -1 idle, 2 waiting, 6/7 acknowledge pair, 8 late release.
    int m_pos = -1;
    bit m_even = 0, m_seen_hi = 0, m_pending = 0, m_rd = 0, m_abort = 0;

    always @(posedge clk2x) begin
        bit rising;
        rising = !m_even;
        m_abort = 0;
        if (!rst_n) begin
            m_pos = -1; m_even = 0; m_seen_hi = 0; m_pending = 0; m_rd = 0;
        end else begin
            if (m_pos == -1) begin
                m_pending = 0;
                if (rising && m_seen_hi && !cs_n) begin m_pos = 2; m_rd = is_read; end
            end else if (m_pos == 2) begin
                if (cs_n) begin m_pos = -1; m_abort = 1; end
                else if (rising && (m_pending || xfer_done)) begin m_pos = 6; m_pending = 0; end
                else if (xfer_done) m_pending = 1;
            end else if (m_pos == 6) m_pos = 7;
            else if (m_pos == 7) m_pos = cs_n ? -1 : 8;
            else if (m_pos == 8) begin if (cs_n) m_pos = -1; end
            if (rising) m_seen_hi = cs_n;
            m_even = !m_even;
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk2x) begin
        if (rst_n && !done_run) begin
            bit e_ack;
            e_ack = (m_pos == 6) || (m_pos == 7) || (m_pos == 8 && !cs_n);
            chk(acc_ack == e_ack, "R3 model ack", acc_ack, e_ack);
            chk(dbus_oe == (e_ack && m_rd), "R8 model oe", dbus_oe, e_ack && m_rd);
            chk(dbus_out == ((e_ack && m_rd) ? rd_data : '0), "R9 model data", dbus_out,
                (e_ack && m_rd) ? rd_data : '0);
            chk(abort_pulse == m_abort, "R7 model abort", abort_pulse, m_abort);
            chk(bclk_hi == m_even, "R10 model phase", bclk_hi, m_even);
        end
    end

    task automatic step();
        @(posedge clk2x); #1;
    endtask

    task automatic to_odd();
        while (bclk_hi) step();
    endtask

    // Qualify chip select, then start an access; returns in state S2.
    task automatic begin_acc(input bit rd);
        cs_n = 1'b1;
        to_odd(); step();
        to_odd();
        cs_n = 1'b0; is_read = rd;
        step();
    endtask

    // From S2, pulse completion in S5; returns in S6.
    task automatic finish_xfer();
        step(); step(); step();
        xfer_done = 1'b1;
        step();
        xfer_done = 1'b0;
    endtask

    initial begin
        repeat (3) step();
        chk(acc_ack == 0 && dbus_oe == 0 && abort_pulse == 0, "R1 in reset", acc_ack, 0);
        chk(dbus_out == 0 && bclk_hi == 0, "R1 bus/phase in reset", bclk_hi, 0);
        rst_n = 1'b1;
        #3;
        chk(acc_ack == 0 && bclk_hi == 0 && dbus_out == 0, "R1 after release", bclk_hi, 0);
        step();
        chk(bclk_hi == 1, "R10 first toggle", bclk_hi, 1);
        step();
        chk(bclk_hi == 0, "R10 second toggle", bclk_hi, 0);

        // Read with synchronous release.
        begin_acc(1'b1);
        chk(acc_ack == 0, "R9 waiting no ack", acc_ack, 0);
        finish_xfer();
        chk(acc_ack == 1 && bclk_hi == 1, "R3 ack in S6", acc_ack, 1);
        chk(dbus_oe == 1 && dbus_out == rd_data, "R8 read data driven", dbus_out, rd_data);
        step();
        cs_n = 1'b1; #1;
        chk(acc_ack == 1, "R4 ack held in S7 after cs release", acc_ack, 1);
        step();
        chk(acc_ack == 0, "R5 sync negation at S8", acc_ack, 0);
        chk(dbus_oe == 0 && dbus_out == 0, "R9 bus quiet after access", dbus_out, 0);

        // Write with late release, then an unqualified reassertion.
        rd_data = 32'h5A5A_F00D;
        begin_acc(1'b0);
        finish_xfer();
        chk(acc_ack == 1 && dbus_oe == 0, "R8 write never drives", dbus_oe, 0);
        step(); step();
        chk(acc_ack == 1, "R6 ack kept at S8 with cs held", acc_ack, 1);
        step(); step();
        cs_n = 1'b1; #1;
        chk(acc_ack == 0, "R6 async negation", acc_ack, 1'b0);
        step();
        cs_n = 1'b0;
        for (int i = 0; i < 8; i++) begin
            xfer_done = (i == 3);
            step();
            chk(acc_ack == 0, "R2 no start without high at rising edge", acc_ack, 0);
        end
        xfer_done = 1'b0;

        // Read with late release: drivers follow chip select.
        rd_data = 32'h0BAD_BEEF;
        begin_acc(1'b1);
        finish_xfer();
        step(); step(); step();
        chk(dbus_oe == 1 && dbus_out == rd_data, "R8 late read still driven", dbus_out, rd_data);
        cs_n = 1'b1; #1;
        chk(dbus_oe == 0 && dbus_out == 0, "R8 drivers off with cs", dbus_oe, 0);
        step();

        // Early release aborts.
        begin_acc(1'b1);
        step();
        cs_n = 1'b1;
        step();
        chk(abort_pulse == 1 && acc_ack == 0, "R7 abort pulse", abort_pulse, 1);
        step();
        chk(abort_pulse == 0, "R7 abort one cycle", abort_pulse, 0);
        xfer_done = 1'b0;
        repeat (4) step();
        chk(acc_ack == 0 && dbus_oe == 0, "R9 idle after abort", acc_ack, 0);

        // Qualified start works after abort.
        begin_acc(1'b0);
        finish_xfer();
        chk(acc_ack == 1, "R2 start after qualified release", acc_ack, 1);
        step();
        cs_n = 1'b1;
        step(); step();

        done_run = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk2x);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule